// File: doc/BRIEF.md
# Polyphase Filter Bank Front-End

This block is the windowed FIR stage that sits ahead of an N-point FFT to form a polyphase filter bank. A single stream of real two's-complement samples in [-1, 1) arrives together with a one-cycle sync pulse. Each accepted sample is routed to one of `NCHAN` branches according to its position in the current frame. Each branch is an `NTAP`-tap FIR filter whose taps lie exactly one frame (`NCHAN` samples) apart in delay memory. Every input sample produces one output sample. That output is the weighted sum of the current sample and the samples at the same frame position in the previous `NTAP-1` frames. The result is rounded and saturated, then handed to the FFT that follows.

The coefficients are fixed at elaboration. Each one is a sample of sin(x)/x multiplied by a selectable window, so every FFT bin gets a flat, steep-sided channel response instead of a plain sinc. The default is 16 branches with 8 taps each and a Hamming window. The output carries a sync pulse that is the input sync delayed by the fixed pipeline latency, so the downstream FFT can align to frame boundaries the same way this block does. Until enough frames have passed to fill every tap, the missing history is treated as zero, and the outputs are marked as not yet settled.

Top module: `pfb_frontend`

## Requirements
- R1: The first accepted sample (`in_valid` high) after an `in_sync` pulse has frame position 0. Each later accepted sample advances the position by one, and the position wraps from `NCHAN-1` to 0. Cycles with `in_valid` low do not advance the position. A sample accepted in the same cycle as `in_sync` keeps its current position, and the next sample is position 0.
- R2: For a sample at position k, the output equals sum over t = 0..NTAP-1 of c[t*NCHAN+k] * x_t, where x_0 is the current sample and x_t is the sample accepted at position k exactly t frames earlier.
- R3: With the default Hamming window, c[i] = round-half-away(sinc((i - NCHAN*NTAP/2)/NCHAN) * (0.54 - 0.46*cos(2*pi*i/(NCHAN*NTAP))) * (2^(CW-1)-1)), where sinc(x) = sin(pi*x)/(pi*x) and sinc(0) = 1.
- R4: The full-precision sum is rounded by adding 2^(CW-2) and then shifting arithmetically right by CW-1 bits (floor).
- R5: The rounded value is saturated to the range [-2^(OW-1), 2^(OW-1)-1].
- R6: Let F be the number of complete frames (position NCHAN-1 accepted) seen since reset, capped at NTAP-1. A tap t with t > F contributes zero. `out_settled` is high exactly for outputs whose sample was accepted once F reached NTAP-1, and it never falls again before reset.
- R7: The output for a sample accepted at a rising edge appears with `out_valid` high after the third following rising edge, counting that edge as the first. Outputs keep their input order.
- R8: `out_sync` equals `in_sync` delayed by the same three cycles, independent of `in_valid`.
- R9: While `out_valid` is low, `out_data` holds its previous value.
- R10: After reset, `out_valid`, `out_sync`, `out_settled` and `out_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample is present this cycle |
| in_sync | input | 1 | Next accepted sample starts a frame |
| in_data | input | DW | Input sample, signed fixed-point in [-1, 1) |
| out_valid | output | 1 | Output sample is present this cycle |
| out_sync | output | 1 | Input sync delayed by the pipeline latency |
| out_settled | output | 1 | Every tap of this output held real history |
| out_data | output | OW | Filtered output, signed fixed-point, rounded and saturated |

## Verification
The frame-position counter and the delay memory are internal state, but errors in either show up at the ports. A position error or a tap taken from the wrong frame gives a wrong `out_data`, three cycles after the affected sample is accepted. A wrong coefficient or a broken mask also gives a wrong output value. Errors in the history counter show up at once in `out_settled`, or as early taps that should still be zero. A stream that starts with an impulse, followed by patterns with valid gaps, mid-frame resyncs and sign-matched full-scale frames, lets each branch and tap be compared with values worked out in the bench.

// File: rtl/pfb_pkg.sv
package pfb_pkg;

    typedef enum logic [1:0] {
        WIN_RECT    = 2'd0,
        WIN_HAMMING = 2'd1,
        WIN_HANN    = 2'd2
    } window_e;

    // Quantized windowed-sinc prototype coefficient at flat index idx.
    function automatic int coef_value(int idx, int nchan, int ntap, int cw, window_e win);
        real pi;
        real arg;
        real sinc;
        real wgt;
        real scale;
        real v;
        int  mid;
        pi  = 3.14159265358979;
        mid = (nchan * ntap) / 2;
        arg = pi * real'(idx - mid) / real'(nchan);
        if (idx == mid) begin
            sinc = 1.0;
        end else begin
            sinc = $sin(arg) / arg;
        end
        case (win)
            WIN_HAMMING: wgt = 0.54 - 0.46 * $cos(2.0 * pi * real'(idx) / real'(nchan * ntap));
            WIN_HANN:    wgt = 0.5 - 0.5 * $cos(2.0 * pi * real'(idx) / real'(nchan * ntap));
            default:     wgt = 1.0;
        endcase
        scale = real'((1 << (cw - 1)) - 1);
        v = sinc * wgt * scale;
        if (v >= 0.0) begin
            return $rtoi(v + 0.5);
        end
        return -$rtoi(0.5 - v);
    endfunction

endpackage

// File: rtl/pfb_branch_ctrl.sv
module pfb_branch_ctrl #(
    parameter int NCHAN = 16,
    parameter int NTAP  = 8,
    localparam int IW   = $clog2(NCHAN),
    localparam int FW   = (NTAP > 1) ? $clog2(NTAP) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic            in_sync,
    output logic [IW-1:0]   pos,
    output logic [NTAP-1:0] live,
    output logic            settled
);

    typedef struct packed {
        logic [IW-1:0] pos;
        logic [FW-1:0] frames;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (in_valid) begin
            if (st_q.pos == IW'(NCHAN - 1)) begin
                st_d.pos = '0;
                if (st_q.frames != FW'(NTAP - 1)) begin
                    st_d.frames = st_q.frames + 1'b1;
                end
            end else begin
                st_d.pos = st_q.pos + 1'b1;
            end
        end
        if (in_sync) begin
            st_d.pos = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar gt = 0; gt < NTAP; gt++) begin : g_live
        assign live[gt] = (int'(st_q.frames) >= gt);
    end

    assign pos     = st_q.pos;
    assign settled = (st_q.frames == FW'(NTAP - 1));

endmodule

// File: rtl/pfb_delay_line.sv
module pfb_delay_line #(
    parameter int NCHAN = 16,
    parameter int NTAP  = 8,
    parameter int DW    = 8,
    localparam int IW   = $clog2(NCHAN)
) (
    input  logic                      clk,
    input  logic                      in_valid,
    input  logic [IW-1:0]             pos,
    input  logic [DW-1:0]             sample,
    output logic [NTAP-1:0][DW-1:0]   taps
);

    assign taps[0] = sample;

    if (NTAP > 1) begin : g_mem
        localparam int DEPTH = NTAP - 1;

        logic [DW-1:0] mem_d [DEPTH][NCHAN];
        logic [DW-1:0] mem_q [DEPTH][NCHAN];

        always_comb begin
            mem_d = mem_q;
            if (in_valid) begin
                mem_d[0][pos] = sample;
                for (int t = 1; t < DEPTH; t++) begin
                    mem_d[t][pos] = mem_q[t-1][pos];
                end
            end
        end

        always_ff @(posedge clk) begin
            mem_q <= mem_d;
        end

        for (genvar gt = 1; gt < NTAP; gt++) begin : g_rd
            assign taps[gt] = mem_q[gt-1][pos];
        end
    end

endmodule

// File: rtl/pfb_mac.sv
module pfb_mac
    import pfb_pkg::*;
#(
    parameter int      NCHAN  = 16,
    parameter int      NTAP   = 8,
    parameter int      DW     = 8,
    parameter int      CW     = 12,
    parameter int      OW     = 8,
    parameter window_e WINDOW = WIN_HAMMING,
    localparam int IW    = $clog2(NCHAN),
    localparam int NCOEF = NCHAN * NTAP,
    localparam int CIW   = $clog2(NCOEF),
    localparam int PW    = DW + CW,
    localparam int RW    = PW + $clog2(NTAP) + 2,
    localparam int SHIFT = CW - 1,
    localparam int HALF  = 1 << (SHIFT - 1),
    localparam int MAXV  = (1 << (OW - 1)) - 1,
    localparam int MINV  = -(1 << (OW - 1))
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [IW-1:0]            in_pos,
    input  logic [NTAP-1:0][DW-1:0]  in_taps,
    output logic [OW-1:0]            out_data
);

    logic [CW-1:0] rom [NCOEF];

    for (genvar gi = 0; gi < NCOEF; gi++) begin : g_rom
        localparam int CV = coef_value(gi, NCHAN, NTAP, CW, WINDOW);
        assign rom[gi] = CV[CW-1:0];
    end

    typedef struct packed {
        logic [NTAP-1:0][PW-1:0] prod;
        logic                    v2;
        logic [OW-1:0]           res;
    } mac_st_t;

    mac_st_t st_d, st_q;

    logic [NTAP-1:0][CW-1:0] coef;
    logic signed [RW-1:0]    acc;
    logic signed [RW-1:0]    rnd;
    logic signed [RW-1:0]    shf;
    logic [OW-1:0]           sat;

    function automatic logic [PW-1:0] smul(logic [DW-1:0] a, logic [CW-1:0] b);
        logic signed [PW-1:0] ea;
        logic signed [PW-1:0] eb;
        ea = PW'($signed(a));
        eb = PW'($signed(b));
        return ea * eb;
    endfunction

    always_comb begin
        for (int t = 0; t < NTAP; t++) begin
            coef[t] = rom[CIW'(t * NCHAN) + CIW'(in_pos)];
        end
    end

    always_comb begin
        acc = '0;
        for (int t = 0; t < NTAP; t++) begin
            acc = acc + RW'($signed(st_q.prod[t]));
        end
        rnd = acc + RW'(HALF);
        shf = rnd >>> SHIFT;
        if (shf > RW'(MAXV)) begin
            sat = OW'(MAXV);
        end else if (shf < RW'(MINV)) begin
            sat = OW'(MINV);
        end else begin
            sat = shf[OW-1:0];
        end
    end

    always_comb begin
        st_d    = st_q;
        st_d.v2 = in_valid;
        if (in_valid) begin
            for (int t = 0; t < NTAP; t++) begin
                st_d.prod[t] = smul(in_taps[t], coef[t]);
            end
        end
        if (st_q.v2) begin
            st_d.res = sat;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_data = st_q.res;

endmodule

// File: rtl/pfb_frontend.sv
module pfb_frontend
    import pfb_pkg::*;
#(
    parameter int      NCHAN  = 16,
    parameter int      NTAP   = 8,
    parameter int      DW     = 8,
    parameter int      CW     = 12,
    parameter int      OW     = 8,
    parameter window_e WINDOW = WIN_HAMMING
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_sync,
    input  logic [DW-1:0] in_data,
    output logic          out_valid,
    output logic          out_sync,
    output logic          out_settled,
    output logic [OW-1:0] out_data
);

    localparam int IW  = $clog2(NCHAN);
    localparam int LAT = 3;

    typedef struct packed {
        logic [NTAP-1:0][DW-1:0] taps;
        logic [IW-1:0]           pos;
        logic [LAT-1:0]          vpipe;
        logic [LAT-1:0]          spipe;
        logic [LAT-1:0]          setpipe;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [IW-1:0]           cur_pos;
    logic [NTAP-1:0]         live;
    logic                    settled;
    logic [NTAP-1:0][DW-1:0] raw_taps;

    pfb_branch_ctrl #(
        .NCHAN (NCHAN),
        .NTAP  (NTAP)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_sync  (in_sync),
        .pos      (cur_pos),
        .live     (live),
        .settled  (settled)
    );

    pfb_delay_line #(
        .NCHAN (NCHAN),
        .NTAP  (NTAP),
        .DW    (DW)
    ) u_dly (
        .clk      (clk),
        .in_valid (in_valid),
        .pos      (cur_pos),
        .sample   (in_data),
        .taps     (raw_taps)
    );

    always_comb begin
        st_d       = st_q;
        st_d.vpipe = {st_q.vpipe[LAT-2:0], in_valid};
        st_d.spipe = {st_q.spipe[LAT-2:0], in_sync};
        if (in_valid) begin
            st_d.pos        = cur_pos;
            st_d.setpipe[0] = settled;
            for (int t = 0; t < NTAP; t++) begin
                st_d.taps[t] = live[t] ? raw_taps[t] : '0;
            end
        end
        for (int s = 1; s < LAT; s++) begin
            if (st_q.vpipe[s-1]) begin
                st_d.setpipe[s] = st_q.setpipe[s-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    pfb_mac #(
        .NCHAN  (NCHAN),
        .NTAP   (NTAP),
        .DW     (DW),
        .CW     (CW),
        .OW     (OW),
        .WINDOW (WINDOW)
    ) u_mac (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (st_q.vpipe[0]),
        .in_pos   (st_q.pos),
        .in_taps  (st_q.taps),
        .out_data (out_data)
    );

    assign out_valid   = st_q.vpipe[LAT-1];
    assign out_sync    = st_q.spipe[LAT-1];
    assign out_settled = st_q.setpipe[LAT-1];

endmodule

// File: rtl/pfb_frontend_chk.sv
module pfb_frontend_chk #(
    parameter int OW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_sync,
    input logic          out_valid,
    input logic          out_sync,
    input logic          out_settled,
    input logic [OW-1:0] out_data
);

    logic [1:0] cyc;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc <= '0;
        end else if (cyc != 2'd3) begin
            cyc <= cyc + 1'b1;
        end
    end

    p_valid_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    p_sync_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 2'd3) |-> (out_sync == $past(in_sync, 3)));

    p_settled_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_settled |=> out_settled);

    p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_data));

endmodule

bind pfb_frontend pfb_frontend_chk #(.OW(OW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_sync     (in_sync),
    .out_valid   (out_valid),
    .out_sync    (out_sync),
    .out_settled (out_settled),
    .out_data    (out_data)
);

// File: tb/pfb_frontend_bench.sv
module pfb_frontend_bench;

    localparam int  N    = 16;
    localparam int  T    = 8;
    localparam int  DW   = 8;
    localparam int  CW   = 12;
    localparam int  OW   = 8;
    localparam real PI   = 3.14159265358979;
    localparam int  OMAX = (1 << (OW - 1)) - 1;
    localparam int  OMIN = -(1 << (OW - 1));

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_sync = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          out_valid;
    logic          out_sync;
    logic          out_settled;
    logic [OW-1:0] out_data;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pfb_frontend #(
        .NCHAN (N),
        .NTAP  (T),
        .DW    (DW),
        .CW    (CW),
        .OW    (OW)
    ) u_pfb_frontend (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_sync     (in_sync),
        .in_data     (in_data),
        .out_valid   (out_valid),
        .out_sync    (out_sync),
        .out_settled (out_settled),
        .out_data    (out_data)
    );

    int    h [N*T];
    int    hist [T-1][N];
    int    fdone = 0;
    int    midx = 0;
    int    sat_hits = 0;
    int    exp_q [$];
    bit    set_q [$];
    string tag_q [$];
    logic [2:0] vsh = '0;
    logic [2:0] ssh = '0;
    logic [OW-1:0] last_out = '0;
    bit    mon_on = 1'b0;
    int    seed = 32'h1234;

    task automatic check(bit ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
        end
    endtask

    function automatic int ref_coef(int i);
        real x;
        real s;
        real w;
        real v;
        x = (real'(i) - real'(N * T) / 2.0) / real'(N);
        if (x == 0.0) s = 1.0;
        else s = $sin(PI * x) / (PI * x);
        w = 0.54 - 0.46 * $cos(2.0 * PI * real'(i) / real'(N * T));
        v = s * w * real'((1 << (CW - 1)) - 1);
        if (v < 0.0) return -$rtoi(0.5 - v);
        return $rtoi(v + 0.5);
    endfunction

    // Reference model of one accepted sample (R1, R2, R4, R5, R6)
    function automatic void model(int x, bit snc, string tag);
        longint acc;
        longint r;
        int v;
        acc = 0;
        for (int t = 0; t < T; t++) begin
            v = (t == 0) ? x : hist[t-1][midx];
            if (t <= fdone) acc += longint'(h[t*N + midx]) * longint'(v);
        end
        r = (acc + longint'(1 << (CW - 2))) >>> (CW - 1);
        if (r > OMAX) begin r = OMAX; sat_hits++; end
        if (r < OMIN) begin r = OMIN; sat_hits++; end
        exp_q.push_back(int'(r));
        set_q.push_back(fdone == T - 1);
        tag_q.push_back(tag);
        for (int t = T - 2; t >= 1; t--) hist[t][midx] = hist[t-1][midx];
        hist[0][midx] = x;
        if (midx == N - 1) begin
            midx = 0;
            if (fdone < T - 1) fdone++;
        end else begin
            midx++;
        end
        if (snc) midx = 0;
    endfunction

    task automatic send(int x, bit snc, string tag);
        @(negedge clk);
        in_valid = 1'b1;
        in_sync  = snc;
        in_data  = x[DW-1:0];
        model(x, snc, tag);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_sync  = 1'b0;
        end
    endtask

    task automatic sync_only();
        @(negedge clk);
        in_valid = 1'b0;
        in_sync  = 1'b1;
        midx = 0;
    endtask

    function automatic int lcg();
        seed = seed * 1103515245 + 12345;
        return ((seed >>> 16) & 255) - 128;
    endfunction

    always @(posedge clk) begin
        vsh <= {vsh[1:0], in_valid};
        ssh <= {ssh[1:0], in_sync};
    end

    always @(negedge clk) begin
        if (mon_on) begin
            check(out_sync == ssh[2], "R8", int'(out_sync), int'(ssh[2]));
            check(out_valid == vsh[2], "R7", int'(out_valid), int'(vsh[2]));
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7", 1, 0);
                end else begin
                    int    e;
                    bit    s;
                    string tg;
                    e  = exp_q.pop_front();
                    s  = set_q.pop_front();
                    tg = tag_q.pop_front();
                    check($signed(out_data) == e, {tg, " R2 R4"}, int'($signed(out_data)), e);
                    check(out_settled == s, "R6", int'(out_settled), int'(s));
                end
            end else begin
                check(out_data == last_out, "R9", int'($signed(out_data)), int'($signed(last_out)));
            end
            last_out = out_data;
        end
    end

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < N * T; i++) h[i] = ref_coef(i);
        for (int t = 0; t < T - 1; t++)
            for (int k = 0; k < N; k++) hist[t][k] = 0;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        check(out_valid == 1'b0, "R10", int'(out_valid), 0);
        check(out_sync == 1'b0, "R10", int'(out_sync), 0);
        check(out_settled == 1'b0, "R10", int'(out_settled), 0);
        check(out_data == '0, "R10", int'(out_data), 0);
        mon_on = 1'b1;

        // Impulse at position 5 in first frame: reveals c[t*N+5] (R3, R6)
        sync_only();
        for (int f = 0; f < T + 1; f++)
            for (int k = 0; k < N; k++)
                send((f == 0 && k == 5) ? 100 : 0, 1'b0, "R3 R6");
        // Direct coefficient spot-check: the impulse reaches tap 4 in frame 4
        check(h[4*N + 5] != 0, "R3", h[4*N + 5], 1);

        // Pseudo-random data with valid gaps (R1, R2)
        for (int i = 0; i < 6 * N; i++) begin
            send(lcg(), 1'b0, "R1");
            if (i % 3 == 2) idle(1 + (i % 2));
        end

        // Mid-frame resync: sync on an accepted sample, then on an idle cycle (R1)
        for (int i = 0; i < 5; i++) send(lcg(), 1'b0, "R1");
        send(lcg(), 1'b1, "R1");
        for (int i = 0; i < N + 3; i++) send(lcg(), 1'b0, "R1");
        sync_only();
        for (int i = 0; i < 2 * N; i++) send(lcg(), 1'b0, "R1");

        // Sign-matched full-scale frames driving positive then negative saturation (R5)
        sync_only();
        for (int j = 0; j < T; j++)
            for (int k = 0; k < N; k++)
                send((h[(T-1-j)*N + k] >= 0) ? 127 : -128, 1'b0, "R5");
        for (int j = 0; j < T; j++)
            for (int k = 0; k < N; k++)
                send((h[(T-1-j)*N + k] >= 0) ? -128 : 127, 1'b0, "R5");
        for (int k = 0; k < N; k++) send(0, 1'b0, "R5");

        idle(8);
        check(exp_q.size() == 0, "R7", exp_q.size(), 0);
        check(sat_hits > 0, "R5", sat_hits, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule